// File: doc/BRIEF.md
# Conversion Group Result Buffer

This block holds the conversion results of one converter group until a host reads them. The sequencer side pushes one result per cycle through a valid strobe. The host takes results out in first-in first-out order through a read request, and the data appears one cycle after the request. The block also signals when the group's channel list has been completed, through a strobe from the sequencer.

A signed threshold counter is loaded by the host before the group starts converting. Each stored result lowers it by one and each result the host reads raises it by one, so the host can be told when a chosen number of results has built up. Three sticky flags record three events: the threshold was reached, the group ended, and a result arrived while the buffer was full. Each flag drives an interrupt output through its own enable bit, and the host clears the flags with a write-one-to-clear access. A policy bit selects what happens to a result that arrives while the buffer is full: it is dropped, or it overwrites the oldest entry.

The host configures the block through a small register port. Address 0 loads the threshold. Address 1 sets the buffer depth. Address 2 holds the enables and the policy bit. Address 3 clears flags.

Top module: `grp_result_buf`

## Requirements
- R1: After reset the buffer is empty, `held_count` is 0, `thr_count` is 0, all flags and interrupt outputs are 0, `rd_data` is 0 and the depth is MAX_DEPTH.
- R2: Results are returned in the order they were stored. A read request in one cycle presents the result on `rd_data` after the next clock edge.
- R3: A write to address 0 loads bits [THR_W-1:0] as a signed threshold, sets `thr_count` to it and empties the buffer. A write to address 1 sets the depth to the written value (0 or more than MAX_DEPTH gives MAX_DEPTH), empties the buffer and reloads `thr_count` from the threshold.
- R4: `thr_count` drops by one for each stored result and rises by one for each result read. When a store and a read happen in the same cycle it keeps its value, and it can go below zero.
- R5: The threshold flag (bit 0 of `flags`) is set only when `thr_count` goes from +1 to 0. It is not set when the count stays at 0 or comes up from -1 to 0.
- R6: `held_count` always equals the loaded threshold minus `thr_count`.
- R7: A pulse on `grp_done` sets the end flag (bit 1 of `flags`).
- R8: When the policy bit (address 2, bit 3) is 0, a result that arrives at a full buffer is discarded, the contents and the counts are unchanged, and the overrun flag (bit 2 of `flags`) is set.
- R9: When the policy bit is 1, a result that arrives at a full buffer replaces the oldest entry. `held_count` stays at the depth, `thr_count` is unchanged and the overrun flag is set.
- R10: A read from an empty buffer gives `rd_data` = 0 and changes neither the counts nor the order of later results.
- R11: Each interrupt output equals its flag ANDed with its enable: address 2 bit 0 for threshold, bit 1 for end and bit 2 for overrun.
- R12: Writing 1 to bits 0, 1 or 2 at address 3 clears the matching flag. A flag that is set and cleared in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cv_valid | input | 1 | Converter result strobe |
| cv_data | input | DATA_W | Converter result |
| grp_done | input | 1 | End-of-group strobe from the sequencer |
| rd_req | input | 1 | Host read request |
| rd_data | output | DATA_W | Read result, valid the cycle after the request |
| held_count | output | DEP_W | Number of results held |
| thr_count | output | THR_W+1 | Signed threshold counter |
| flags | output | 3 | Sticky flags {overrun, end, threshold} |
| irq_thr | output | 1 | Threshold interrupt |
| irq_end | output | 1 | Group end interrupt |
| irq_ovr | output | 1 | Overrun interrupt |

## Verification
The assertions assume that the host programs the threshold so that the threshold minus the depth still fits in the THR_W+1 bit counter. Under that condition the held count and the counter can never disagree. They also assume that no result is pushed or read in the same cycle as a threshold or depth write, because those writes flush the buffer. The bench writes its configuration only while both strobes are low, and it uses thresholds of at most a few units. Inputs change only on the falling clock edge, so each property sees stable values at the rising edge.

// File: rtl/grb_pkg.sv
// Package: shared constants for the group result buffer.
// Assumes: nothing beyond the 2-bit register address space.
package grb_pkg;
    localparam int FLAG_N = 3;
    localparam int F_THR  = 0;
    localparam int F_END  = 1;
    localparam int F_OVR  = 2;

    typedef enum logic [1:0] {
        A_THRESH = 2'd0,
        A_DEPTH  = 2'd1,
        A_CTRL   = 2'd2,
        A_CLEAR  = 2'd3
    } reg_addr_e;

    typedef enum logic {
        POL_DROP      = 1'b0,
        POL_OVERWRITE = 1'b1
    } ovr_policy_e;
endpackage

// File: rtl/grb_store.sv
// Module: circular result storage with a run-time depth.
// Does: keeps pointers and the held count, decides which pushes and reads take
// effect, and applies the full-buffer policy.
// Assumes: depth is between 1 and MAX_DEPTH; flush clears the buffer and masks
// all pushes and reads in its cycle.
module grb_store #(
    parameter int DATA_W    = 12,
    parameter int MAX_DEPTH = 16,
    parameter int DEP_W     = $clog2(MAX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [DEP_W-1:0]  depth,
    input  logic              overwrite,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [DEP_W-1:0]  count,
    output logic              wr_take,
    output logic              rd_take,
    output logic              ovr_evt
);
    localparam int IDX_W = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;

    logic [DATA_W-1:0] mem [MAX_DEPTH];
    logic [IDX_W-1:0]  wptr, rptr;
    logic              full, empty, ovw;
    logic [IDX_W-1:0]  last_idx;

    // Derive the per-cycle events from the current fill level.
    always_comb begin
        last_idx = IDX_W'(depth - 1'b1);
        full     = (count == depth);
        empty    = (count == '0);
        rd_take  = pop && !empty && !flush;
        wr_take  = push && !flush && (!full || rd_take);
        ovr_evt  = push && !flush && full && !rd_take;
        ovw      = ovr_evt && overwrite;
    end

    // Advance the pointers and the held count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_take || ovw)
                wptr <= (wptr == last_idx) ? '0 : wptr + 1'b1;
            if (rd_take || ovw)
                rptr <= (rptr == last_idx) ? '0 : rptr + 1'b1;
            if (wr_take && !rd_take)
                count <= count + 1'b1;
            else if (rd_take && !wr_take)
                count <= count - 1'b1;
        end
    end

    // Store accepted and overwriting results.
    always_ff @(posedge clk) begin
        if (wr_take || ovw)
            mem[wptr] <= push_data;
    end

    // Register the read result; an empty read returns zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pop_data <= '0;
        else if (pop && !flush)
            pop_data <= rd_take ? mem[rptr] : '0;
    end

    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= depth);
    a_r8_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt && !overwrite |=> count == $past(count));
    a_r10_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pop && empty && !flush |=> pop_data == '0);
endmodule

// File: rtl/grb_thresh.sv
// Module: signed threshold counter.
// Does: loads the threshold, counts down on stores and up on reads, and
// gives a strobe when the count moves from +1 to 0.
// Assumes: the count range CNT_W holds threshold minus depth.
module grb_thresh #(
    parameter int CNT_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic signed [CNT_W-1:0] load_val,
    input  logic                    dec,
    input  logic                    inc,
    output logic signed [CNT_W-1:0] cnt,
    output logic                    hit_zero
);
    localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

    // Detect the one transition that may raise the threshold flag.
    always_comb hit_zero = !load && dec && !inc && (cnt == ONE);

    // Update the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec && !inc)
            cnt <= cnt - ONE;
        else if (inc && !dec)
            cnt <= cnt + ONE;
    end

    a_r4_pair_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load && dec && inc |=> cnt == $past(cnt));
    a_r4_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        !load && dec && !inc |=> cnt == $past(cnt) - ONE);
endmodule

// File: rtl/grb_flags.sv
// Module: sticky event flags with enables.
// Does: sets a flag on its event, clears it on a host clear, and gates the
// interrupt output with the enable. A set wins over a clear in the same cycle.
// Assumes: set and clr are single-cycle strobes.
module grb_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] flag,
    output logic [N-1:0] irq
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Hold one sticky flag.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag[i] <= 1'b0;
            else if (set[i])
                flag[i] <= 1'b1;
            else if (clr[i])
                flag[i] <= 1'b0;
        end

        // Gate the interrupt line.
        always_comb irq[i] = flag[i] & en[i];

        a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flag[i]);
        a_r12_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] && !set[i] |=> !flag[i]);
    end
endmodule

// File: rtl/grp_result_buf.sv
// Module: result buffer for one conversion group (top).
// Does: decodes the register port, and ties together the storage, the
// threshold counter and the sticky flags.
// Assumes: no push or read in the same cycle as a threshold or depth write.
module grp_result_buf #(
    parameter int DATA_W    = 12,
    parameter int MAX_DEPTH = 16,
    parameter int THR_W     = 8,
    parameter int DEP_W     = $clog2(MAX_DEPTH + 1),
    parameter int CNT_W     = THR_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic [1:0]              cfg_addr,
    input  logic [15:0]             cfg_wdata,
    input  logic                    cv_valid,
    input  logic [DATA_W-1:0]       cv_data,
    input  logic                    grp_done,
    input  logic                    rd_req,
    output logic [DATA_W-1:0]       rd_data,
    output logic [DEP_W-1:0]        held_count,
    output logic signed [CNT_W-1:0] thr_count,
    output logic [2:0]              flags,
    output logic                    irq_thr,
    output logic                    irq_end,
    output logic                    irq_ovr
);
    import grb_pkg::*;

    localparam logic [DEP_W-1:0] DEP_MAX = DEP_W'(MAX_DEPTH);

    logic signed [THR_W-1:0] thr_reg;
    logic [DEP_W-1:0]        depth_reg;
    logic [FLAG_N-1:0]       en_reg;
    ovr_policy_e             policy;
    logic                    wr_thr, wr_dep, wr_ctl, wr_clr, flush;
    logic                    wr_take, rd_take, ovr_evt, hit_zero;
    logic [FLAG_N-1:0]       set_v, clr_v, irq_v;
    logic signed [CNT_W-1:0] thr_ext;

    // Decode register writes.
    always_comb begin
        wr_thr  = cfg_wr && (cfg_addr == A_THRESH);
        wr_dep  = cfg_wr && (cfg_addr == A_DEPTH);
        wr_ctl  = cfg_wr && (cfg_addr == A_CTRL);
        wr_clr  = cfg_wr && (cfg_addr == A_CLEAR);
        flush   = wr_thr || wr_dep;
        thr_ext = wr_thr ? CNT_W'($signed(cfg_wdata[THR_W-1:0]))
                         : CNT_W'(thr_reg);
    end

    // Hold the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_reg   <= '0;
            depth_reg <= DEP_MAX;
            en_reg    <= '0;
            policy    <= POL_DROP;
        end else begin
            if (wr_thr)
                thr_reg <= $signed(cfg_wdata[THR_W-1:0]);
            if (wr_dep)
                depth_reg <= (cfg_wdata == 16'd0 || cfg_wdata > 16'(MAX_DEPTH))
                             ? DEP_MAX : DEP_W'(cfg_wdata);
            if (wr_ctl) begin
                en_reg <= cfg_wdata[FLAG_N-1:0];
                policy <= ovr_policy_e'(cfg_wdata[3]);
            end
        end
    end

    grb_store #(
        .DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH), .DEP_W(DEP_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .depth(depth_reg),
        .overwrite(policy == POL_OVERWRITE),
        .push(cv_valid), .push_data(cv_data), .pop(rd_req),
        .pop_data(rd_data), .count(held_count),
        .wr_take(wr_take), .rd_take(rd_take), .ovr_evt(ovr_evt)
    );

    grb_thresh #(.CNT_W(CNT_W)) u_thresh (
        .clk(clk), .rst_n(rst_n), .load(flush), .load_val(thr_ext),
        .dec(wr_take), .inc(rd_take), .cnt(thr_count), .hit_zero(hit_zero)
    );

    // Gather the flag events and clears.
    always_comb begin
        set_v        = '0;
        set_v[F_THR] = hit_zero;
        set_v[F_END] = grp_done;
        set_v[F_OVR] = ovr_evt;
        clr_v        = wr_clr ? cfg_wdata[FLAG_N-1:0] : '0;
    end

    grb_flags #(.N(FLAG_N)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v), .en(en_reg),
        .flag(flags), .irq(irq_v)
    );

    // Drive the interrupt outputs.
    always_comb begin
        irq_thr = irq_v[F_THR];
        irq_end = irq_v[F_END];
        irq_ovr = irq_v[F_OVR];
    end

    a_r5_thr_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[F_THR]) |-> ($past(thr_count) == CNT_W'(1)) && (thr_count == '0));
    a_r6_held_match: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(held_count) == CNT_W'(thr_reg) - thr_count);
    a_r9_overwrite_full: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt && policy == POL_OVERWRITE |=> held_count == depth_reg);
endmodule

// File: tb/grp_result_buf_bench.sv
module grp_result_buf_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_addr = '0;
    logic [15:0]   cfg_wdata = '0;
    logic          cv_valid = 1'b0;
    logic [DW-1:0] cv_data = '0;
    logic          grp_done = 1'b0;
    logic          rd_req = 1'b0;
    logic [DW-1:0] rd_data;
    logic [4:0]    held_count;
    logic signed [8:0] thr_count;
    logic [2:0]    flags;
    logic          irq_thr, irq_end, irq_ovr;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    grp_result_buf u_grp_result_buf (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cv_valid(cv_valid), .cv_data(cv_data),
        .grp_done(grp_done), .rd_req(rd_req), .rd_data(rd_data),
        .held_count(held_count), .thr_count(thr_count), .flags(flags),
        .irq_thr(irq_thr), .irq_end(irq_end), .irq_ovr(irq_ovr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic cfg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic push(input int v);
        @(negedge clk);
        cv_valid = 1'b1; cv_data = DW'(v);
        @(negedge clk);
        cv_valid = 1'b0;
    endtask

    task automatic pull(output int v);
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        v = int'(rd_data);
    endtask

    task automatic push_pull(input int v);
        @(negedge clk);
        cv_valid = 1'b1; cv_data = DW'(v); rd_req = 1'b1;
        @(negedge clk);
        cv_valid = 1'b0; rd_req = 1'b0;
    endtask

    task automatic t_reset();
        chk_eq("R1 held", int'(held_count), 0);
        chk_eq("R1 cnt", int'(thr_count), 0);
        chk_eq("R1 flags", int'(flags), 0);
        chk_eq("R1 irq", int'({irq_thr, irq_end, irq_ovr}), 0);
        chk_eq("R1 rd_data", int'(rd_data), 0);
    endtask

    task automatic t_order();
        int v;
        cfg(2'd0, 16'd5);
        chk_eq("R3 load cnt", int'(thr_count), 5);
        for (int i = 0; i < 4; i++) push(100 + i);
        chk_eq("R4 cnt after 4 pushes", int'(thr_count), 1);
        chk_eq("R6 held", int'(held_count), 4);
        for (int i = 0; i < 4; i++) begin
            pull(v);
            chk_eq("R2 order", v, 100 + i);
        end
        chk_eq("R4 cnt back", int'(thr_count), 5);
    endtask

    task automatic t_counter();
        cfg(2'd0, 16'd2);
        push(7);
        push_pull(8);
        chk_eq("R4 pair hold", int'(thr_count), 1);
        chk_eq("R6 held pair", int'(held_count), 1);
        cfg(2'd0, 16'hFFFE);
        chk_eq("R3 negative load", int'(thr_count), -2);
        chk_eq("R3 flush", int'(held_count), 0);
        push(1); push(2);
        chk_eq("R4 below zero", int'(thr_count), -4);
        chk_eq("R6 held neg", int'(held_count), 2);
    endtask

    task automatic t_thr_edge();
        int v;
        cfg(2'd3, 16'h7);
        cfg(2'd0, 16'd2);
        push(1);
        chk_eq("R5 no flag at 1", int'(flags[0]), 0);
        push(2);
        chk_eq("R5 flag on 1->0", int'(flags[0]), 1);
        cfg(2'd3, 16'h1);
        chk_eq("R12 clear thr", int'(flags[0]), 0);
        push_pull(3);
        chk_eq("R5 stays 0 no flag", int'(flags[0]), 0);
        push(4);
        pull(v);
        chk_eq("R5 -1->0 no flag", int'(flags[0]), 0);
        chk_eq("R5 cnt 0", int'(thr_count), 0);
    endtask

    task automatic t_end_irq();
        cfg(2'd3, 16'h7);
        cfg(2'd2, 16'h0);
        @(negedge clk); grp_done = 1'b1;
        @(negedge clk); grp_done = 1'b0;
        chk_eq("R7 end flag", int'(flags[1]), 1);
        chk_eq("R11 irq off", int'(irq_end), 0);
        cfg(2'd2, 16'h2);
        chk_eq("R11 irq on", int'(irq_end), 1);
        // clear and new end in the same cycle: set wins
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 2'd3; cfg_wdata = 16'h2; grp_done = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; grp_done = 1'b0;
        chk_eq("R12 set wins", int'(flags[1]), 1);
        cfg(2'd3, 16'h2);
        chk_eq("R12 clear end", int'(flags[1]), 0);
        chk_eq("R11 irq follows", int'(irq_end), 0);
    endtask

    task automatic t_drop();
        int v;
        cfg(2'd3, 16'h7);
        cfg(2'd2, 16'h4);
        cfg(2'd1, 16'd3);
        cfg(2'd0, 16'd3);
        for (int i = 1; i <= 5; i++) push(i);
        chk_eq("R8 held at depth", int'(held_count), 3);
        chk_eq("R8 cnt", int'(thr_count), 0);
        chk_eq("R8 ovr flag", int'(flags[2]), 1);
        chk_eq("R11 ovr irq", int'(irq_ovr), 1);
        for (int i = 1; i <= 3; i++) begin
            pull(v);
            chk_eq("R8 kept oldest", v, i);
        end
    endtask

    task automatic t_overwrite();
        int v;
        cfg(2'd3, 16'h7);
        cfg(2'd2, 16'h8);
        cfg(2'd1, 16'd4);
        cfg(2'd0, 16'd4);
        for (int i = 1; i <= 6; i++) push(10 + i);
        chk_eq("R9 held", int'(held_count), 4);
        chk_eq("R9 cnt", int'(thr_count), 0);
        chk_eq("R9 ovr flag", int'(flags[2]), 1);
        for (int i = 3; i <= 6; i++) begin
            pull(v);
            chk_eq("R9 newest kept", v, 10 + i);
        end
        chk_eq("R9 cnt back", int'(thr_count), 4);
    endtask

    task automatic t_empty_read();
        int v;
        cfg(2'd1, 16'd0);
        cfg(2'd0, 16'd1);
        push(55);
        pull(v);
        chk_eq("R10 first read", v, 55);
        pull(v);
        chk_eq("R10 empty data", v, 0);
        chk_eq("R10 cnt", int'(thr_count), 1);
        chk_eq("R10 held", int'(held_count), 0);
        push(66);
        pull(v);
        chk_eq("R10 later order", v, 66);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_order();
                t_counter();
                t_thr_edge();
                t_end_irq();
                t_drop();
                t_overwrite();
                t_empty_read();
            end
            begin
                repeat (20000) @(posedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule